// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns an integer held in a 64-bit register operand into a floating-point value in double format. The integer may be signed or unsigned and 32 or 64 bits wide, selected by a 2-bit source-type field. The value is produced either at double precision or at single precision. A single-precision result is rounded to 24 significant bits and then widened, exactly, into double format. A 2-bit rounding mode selects how inexact values are rounded.

A request is accepted on any cycle that `in_valid` is high. Its result appears one cycle later with `out_valid`. The status outputs behave as status register state. The class code, the rounded flag and the inexact flag hold the values left by the most recent conversion that was allowed to update them. The sticky inexact flag accumulates until reset. A conversion from a 32-bit source to double is always exact, so it leaves all status untouched and does not raise the flag-update enable.

Top module: `int2fp_convert`

## Requirements
- R1: `in_type` selects the source: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit. For the 32-bit types only bits 31:0 of the operand are used, and bits 63:32 have no effect on the result.
- R2: A 32-bit source converted with `in_single`=0 gives the exact double value. It drives `out_flag_we` low, and `out_class`, `out_fr`, `out_fi` and `out_xx_sticky` keep their previous values.
- R3: Every other combination of type and precision drives `out_flag_we` high with its result and updates `out_class`, `out_fr` and `out_fi`.
- R4: `in_rmode` selects the rounding: 0 nearest with ties to even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R5: `out_fr` is set when rounding increased the magnitude. `out_fi` is set when the result differs from the integer.
- R6: `out_xx_sticky` is set by any conversion that updates status while inexact. It stays set until reset.
- R7: With `in_single`=1 the value is rounded to a 24-bit significand and then given in double format, so result bits 28:0 are zero.
- R8: A zero source value gives +0.0 (all bits zero). When the conversion updates status, `out_class` becomes 5'b00010.
- R9: Non-zero results are normal doubles with bias 1023. When status is updated, `out_class` becomes 5'b00100 for a positive result and 5'b01000 for a negative one.
- R10: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `out_result` changes only at that time.
- R11: Reset clears every output to zero, including the sticky flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 64 | Integer source operand |
| in_type | input | 2 | Source type select |
| in_single | input | 1 | 1 = round to single precision |
| in_rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_result | output | 64 | Result in double format |
| out_class | output | 5 | Result class code (status) |
| out_fr | output | 1 | Magnitude incremented by rounding (status) |
| out_fi | output | 1 | Inexact result (status) |
| out_xx_sticky | output | 1 | Sticky inexact |
| out_flag_we | output | 1 | Status was updated by this result |

## Verification
On every cycle the assertions check several properties. They check the one-cycle latency of the strobe. They check that an exact 32-bit to double conversion keeps status frozen with the enable low. They check that single-precision results have their low fraction bits cleared and that a zero operand yields all-zero bits. They also check that the sticky flag never drops and that a rounded-up status always comes with inexact. Only the bench's sweeps can show that the rounded bit patterns are numerically correct. This covers every type, precision and rounding mode, including ties, carries into the exponent, the most negative integers and garbage in the unused upper operand bits.

// File: rtl/icvt_pkg.sv
package icvt_pkg;
    localparam int XW      = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int MANT_D  = FRAC_W + 1;
    localparam int MANT_S  = 24;
    localparam int BIAS    = 1023;
    localparam int LZ_W    = $clog2(XW) + 1;

    localparam logic [4:0] CLS_POS_NORM = 5'b00100;
    localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
    localparam logic [4:0] CLS_POS_ZERO = 5'b00010;

    typedef enum logic [1:0] {
        SRC_S32 = 2'd0,
        SRC_U32 = 2'd1,
        SRC_S64 = 2'd2,
        SRC_U64 = 2'd3
    } src_type_e;

    typedef enum logic [1:0] {
        RND_NEAR  = 2'd0,
        RND_ZERO  = 2'd1,
        RND_PINF  = 2'd2,
        RND_NINF  = 2'd3
    } rmode_e;

    typedef struct packed {
        logic            valid;
        logic [XW-1:0]   result;
        logic [4:0]      cls;
        logic            fr;
        logic            fi;
        logic            xx;
        logic            we;
    } icvt_state_t;
endpackage

// File: rtl/icvt_operand.sv
module icvt_operand
    import icvt_pkg::*;
(
    input  logic [XW-1:0] op,
    input  logic [1:0]    src_type,
    output logic          neg,
    output logic [XW-1:0] mag
);
    localparam int HW = XW / 2;
    logic [XW-1:0] ext;

    always_comb begin
        if (!src_type[1]) begin
            ext = src_type[0] ? {{HW{1'b0}}, op[HW-1:0]}
                              : {{HW{op[HW-1]}}, op[HW-1:0]};
        end else begin
            ext = op;
        end
        neg = ~src_type[0] & ext[XW-1];
        mag = neg ? (~ext + XW'(1)) : ext;
    end
endmodule

// File: rtl/icvt_lzc.sv
module icvt_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  din,
    output logic [CW-1:0] count
);
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (din[i]) count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/icvt_round.sv
module icvt_round
    import icvt_pkg::*;
(
    input  logic [XW-1:0]     norm,
    input  logic              single,
    input  logic              neg,
    input  logic [1:0]        rmode,
    output logic [FRAC_W-1:0] frac,
    output logic              carry,
    output logic              inc,
    output logic              inexact
);
    localparam int GPOS_D = XW - MANT_D - 1;
    localparam int GPOS_S = XW - MANT_S - 1;
    localparam int PAD    = MANT_D - MANT_S;

    logic [MANT_D-1:0] keep;
    logic [MANT_D:0]   unit;
    logic [MANT_D:0]   sum;
    logic              guard, sticky, lsb;

    always_comb begin
        if (single) begin
            keep   = {norm[XW-1 -: MANT_S], {PAD{1'b0}}};
            guard  = norm[GPOS_S];
            sticky = |norm[GPOS_S-1:0];
            lsb    = norm[GPOS_S+1];
            unit   = (MANT_D+1)'(1) << PAD;
        end else begin
            keep   = norm[XW-1 -: MANT_D];
            guard  = norm[GPOS_D];
            sticky = |norm[GPOS_D-1:0];
            lsb    = norm[GPOS_D+1];
            unit   = (MANT_D+1)'(1);
        end
        inexact = guard | sticky;
        case (rmode_e'(rmode))
            RND_NEAR: inc = guard & (sticky | lsb);
            RND_ZERO: inc = 1'b0;
            RND_PINF: inc = inexact & ~neg;
            default:  inc = inexact & neg;
        endcase
        sum   = {1'b0, keep} + (inc ? unit : '0);
        carry = sum[MANT_D];
        frac  = sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/int2fp_convert.sv
module int2fp_convert
    import icvt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [63:0]   in_operand,
    input  logic [1:0]    in_type,
    input  logic          in_single,
    input  logic [1:0]    in_rmode,
    output logic          out_valid,
    output logic [63:0]   out_result,
    output logic [4:0]    out_class,
    output logic          out_fr,
    output logic          out_fi,
    output logic          out_xx_sticky,
    output logic          out_flag_we
);
    icvt_state_t state_d, state_q;

    logic              neg_w;
    logic [XW-1:0]     mag_w;
    logic [LZ_W-1:0]   lz_w;
    logic [XW-1:0]     norm_w;
    logic [FRAC_W-1:0] frac_w;
    logic              carry_w, inc_w, inexact_w;
    logic [EXP_W-1:0]  exp_w;
    logic              upd_w;

    icvt_operand u_operand (
        .op       (in_operand),
        .src_type (in_type),
        .neg      (neg_w),
        .mag      (mag_w)
    );

    icvt_lzc #(.W(XW), .CW(LZ_W)) u_lzc (
        .din   (mag_w),
        .count (lz_w)
    );

    assign norm_w = mag_w << lz_w;

    icvt_round u_round (
        .norm    (norm_w),
        .single  (in_single),
        .neg     (neg_w),
        .rmode   (in_rmode),
        .frac    (frac_w),
        .carry   (carry_w),
        .inc     (inc_w),
        .inexact (inexact_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        state_d.we    = 1'b0;
        exp_w         = EXP_W'(BIAS + XW - 1) - EXP_W'(lz_w) + EXP_W'(carry_w);
        upd_w         = in_type[1] | in_single;
        if (in_valid) begin
            state_d.we = upd_w;
            if (mag_w == '0) begin
                state_d.result = '0;
                if (upd_w) begin
                    state_d.cls = CLS_POS_ZERO;
                    state_d.fr  = 1'b0;
                    state_d.fi  = 1'b0;
                end
            end else begin
                state_d.result = {neg_w, exp_w, frac_w};
                if (upd_w) begin
                    state_d.cls = neg_w ? CLS_NEG_NORM : CLS_POS_NORM;
                    state_d.fr  = inc_w;
                    state_d.fi  = inexact_w;
                    state_d.xx  = state_q.xx | inexact_w;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid     = state_q.valid;
    assign out_result    = state_q.result;
    assign out_class     = state_q.cls;
    assign out_fr        = state_q.fr;
    assign out_fi        = state_q.fi;
    assign out_xx_sticky = state_q.xx;
    assign out_flag_we   = state_q.we;

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_result));
    p_exact_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_type[1] && !in_single |=>
            !out_flag_we && $stable(out_class) && $stable(out_fr)
            && $stable(out_fi) && $stable(out_xx_sticky));
    p_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_type[1] || in_single) |=> out_flag_we);
    p_single_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_single |=> out_result[28:0] == 29'd0);
    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_operand == 64'd0 |=> out_result == 64'd0);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_xx_sticky |=> out_xx_sticky);
    p_fr_fi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_fr |-> out_fi);
endmodule

// File: tb/test_int2fp_convert.sv
`timescale 1ns/1ps
module test_int2fp_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_type = '0;
    logic        in_single = 1'b0;
    logic [1:0]  in_rmode = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [4:0]  out_class;
    logic        out_fr, out_fi, out_xx_sticky, out_flag_we;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [4:0] e_cls = '0;
    logic       e_fr = 1'b0, e_fi = 1'b0, e_xx = 1'b0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    int2fp_convert i_int2fp_convert (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_type(in_type), .in_single(in_single), .in_rmode(in_rmode),
        .out_valid(out_valid), .out_result(out_result), .out_class(out_class),
        .out_fr(out_fr), .out_fi(out_fi), .out_xx_sticky(out_xx_sticky),
        .out_flag_we(out_flag_we)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [63:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    function automatic void model(input logic [63:0] op, input logic [1:0] ty,
                                  input logic sg, input logic [1:0] rm,
                                  output logic [63:0] res, output logic [4:0] cls,
                                  output logic fr, output logic fi, output logic we);
        logic neg, up;
        logic [63:0] mag, q, rem, half;
        int msb, p, sh, t;
        we = ty[1] | sg;
        fr = 1'b0;
        fi = 1'b0;
        if (!ty[1]) begin
            neg = !ty[0] && op[31];
            mag = neg ? (64'h1_0000_0000 - {32'b0, op[31:0]}) : {32'b0, op[31:0]};
        end else begin
            neg = !ty[0] && op[63];
            mag = neg ? (64'd0 - op) : op;
        end
        if (mag == 64'd0) begin
            res = 64'd0;
            cls = 5'b00010;
            return;
        end
        msb = 0;
        for (int i = 0; i < 64; i++) if (mag[i]) msb = i;
        p = sg ? 24 : 53;
        if (msb + 1 > p) begin
            sh   = msb + 1 - p;
            q    = mag >> sh;
            rem  = mag & ((64'd1 << sh) - 64'd1);
            half = 64'd1 << (sh - 1);
            case (rm)
                2'd0:    up = (rem > half) || (rem == half && q[0]);
                2'd1:    up = 1'b0;
                2'd2:    up = (rem != 0) && !neg;
                default: up = (rem != 0) && neg;
            endcase
            fi = (rem != 0);
            fr = up;
            q  = q + {63'd0, up};
            t  = p - 1;
            if (q == (64'd1 << p)) begin
                q = q >> 1;
                msb++;
            end
        end else begin
            q = mag;
            t = msb;
        end
        res = {neg, 11'(1023 + msb), 52'((q ^ (64'd1 << t)) << (52 - t))};
        cls = neg ? 5'b01000 : 5'b00100;
    endfunction

    task automatic run(input logic [63:0] op, input logic [1:0] ty,
                       input logic sg, input logic [1:0] rm);
        logic [63:0] res;
        logic [4:0]  cls;
        logic        fr, fi, we;
        string       rtag;
        model(op, ty, sg, rm, res, cls, fr, fi, we);
        @(negedge clk);
        in_valid = 1'b1; in_operand = op; in_type = ty; in_single = sg; in_rmode = rm;
        @(negedge clk);
        in_valid = 1'b0;
        if (sg)          rtag = "R7 single result";
        else if (ty[1])  rtag = "R4 rounded result";
        else             rtag = "R1 32-bit result";
        chk("R10 out_valid", {63'd0, out_valid}, 64'd1);
        chk(rtag, out_result, res);
        if (we) begin
            e_cls = cls; e_fr = fr; e_fi = fi; e_xx = e_xx | fi;
            chk("R3 flag_we", {63'd0, out_flag_we}, 64'd1);
        end else begin
            chk("R2 flag_we", {63'd0, out_flag_we}, 64'd0);
        end
        chk((res == 0) ? "R8 class" : "R9 class", {59'd0, out_class}, {59'd0, e_cls});
        chk("R5 fr", {63'd0, out_fr}, {63'd0, e_fr});
        chk("R5 fi", {63'd0, out_fi}, {63'd0, e_fi});
        chk("R6 sticky", {63'd0, out_xx_sticky}, {63'd0, e_xx});
    endtask

    task automatic check_reset_state();
        chk("R11 valid",  {63'd0, out_valid}, 64'd0);
        chk("R11 result", out_result, 64'd0);
        chk("R11 class",  {59'd0, out_class}, 64'd0);
        chk("R11 flags",  {60'd0, out_fr, out_fi, out_xx_sticky, out_flag_we}, 64'd0);
        e_cls = '0; e_fr = 1'b0; e_fi = 1'b0; e_xx = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] corners [12];
        corners[0]  = 64'd0;
        corners[1]  = 64'd1;
        corners[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
        corners[3]  = 64'hDEAD_BEEF_8000_0000;
        corners[4]  = 64'h8000_0000_0000_0000;
        corners[5]  = 64'h0020_0000_0000_0001;
        corners[6]  = 64'h0020_0000_0000_0003;
        corners[7]  = 64'h1234_5678_0100_0001;
        corners[8]  = 64'hABCD_0000_0100_0003;
        corners[9]  = 64'h7FFF_FFFF_FFFF_FFFF;
        corners[10] = 64'h5555_0000_7FFF_FFFF;
        corners[11] = 64'hFFFF_FFFF_0000_0000;

        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;

        // R9: directly known encodings
        run(64'd1, 2'd3, 1'b0, 2'd0);
        chk("R9 one", out_result, 64'h3FF0_0000_0000_0000);
        run(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 2'd0);
        chk("R9 minus one", out_result, 64'hBFF0_0000_0000_0000);
        // R4: 2^53+1 nearest-even ties down to 2^53, inexact
        run(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'd0);
        chk("R4 tie even", out_result, 64'h4340_0000_0000_0000);
        chk("R5 tie inexact", {63'd0, out_fi}, 64'd1);
        // R1: upper bits ignored for a 32-bit source
        run(64'hFFFF_0000_0000_0002, 2'd1, 1'b0, 2'd0);
        chk("R1 upper ignored", out_result, 64'h4000_0000_0000_0000);

        for (int ty = 0; ty < 4; ty++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int rm = 0; rm < 4; rm++) begin
                    for (int k = 0; k < 12; k++)
                        run(corners[k], 2'(ty), 1'(sg), 2'(rm));
                    for (int k = 0; k < 24; k++) begin
                        logic [63:0] r;
                        r = next_rand();
                        if (k[0]) r = r >> r[5:0];
                        run(r, 2'(ty), 1'(sg), 2'(rm));
                    end
                end
            end
        end

        // R11: reset mid-run clears sticky and status
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        run(64'd3, 2'd0, 1'b0, 2'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule